// File: doc/BRIEF.md
# Multi-Window Line Buffer for Parallel Convolution

This block sits between a stream of incoming feature-map words and a row of multiply-accumulate units. Each input word carries a vector of `PZ` channel values for one pixel. Words arrive row by row. The block keeps a small ring of whole rows. From that ring it serves up to `MAX_NP` neighbouring convolution windows at the same time, one window per read lane. Every cycle, each active lane delivers one window element.

Software sets the layer shape before the layer starts. The shape is the kernel size K (1 or 3), the stride S (1 or 2), the number of lanes in use and the row width. Software then pulses `cfg_load`. The ring holds K+S-1 row slots. A new row is accepted only while a slot is free. The reader starts an output row only once all K input rows under it have been written. Because of this, the writer and the readers never touch the same slot. Within one output row, groups of lanes step across the row, and the windows inside a group sit S pixels apart. When the last group of an output row is done, the reader frees S input rows.

Top module: `mwin_line_buffer`

## Requirements
- R1: While reset is held and just after it, `out_valid` is 0, `out_lane_en` is 0 and `wr_ready` is 1.
- R2: A word is stored when `wr_valid` and `wr_ready` are both 1 at a clock edge. Words fill a row from column 0 to width-1 and then start the next row. An input row counts as complete when its last word is stored.
- R3: One window is K*K output cycles long. Elements come out with the kernel row index in the outer loop and the kernel column index in the inner loop. `out_last` is 1 only on the final element of each window.
- R4: Lane p of a group starting at output column x0 serves output column x0+p. On output row r, kernel element (ky,kx) of that lane is the stored word at input row r*S+ky, column (x0+p)*S+kx. The lane's data appears at `out_data[p*WORD_W +: WORD_W]`. Successive groups start `cfg_np` output columns apart.
- R5: There are (width-K)/S+1 output columns, using integer division. A lane whose column is at or beyond that count, or whose index is at least the loaded lane count, has its `out_lane_en` bit at 0 and its data at 0. When `out_valid` is 0, all lane enables are 0.
- R6: An output element is issued only when the number of complete input rows is at least r*S+K, where r is the current output row. Otherwise `out_valid` stays 0.
- R7: `wr_ready` is 1 exactly when (complete rows - r*S) is less than K+S-1. A word offered while `wr_ready` is 0 is dropped and leaves no trace in the output.
- R8: After the last group of output row r has finished, the reader moves to output row r+1. This frees S input rows, so the `wr_ready` test above uses the new r in the cycle after that group's last element.
- R9: Pulsing `cfg_load` latches the new layer settings and restarts the write and read positions at row 0. The encodings are: `cfg_k` holds 1 or 3, `cfg_s` holds 1 or 2, `cfg_np` holds 1 to `MAX_NP`, and `cfg_width` holds K to `MAX_W`. In the following cycle `out_valid` is 0 and `wr_ready` is 1. Data written before the pulse never appears in the output.
- R10: An element is issued at a clock edge and shows on the outputs right after that edge. `out_valid` therefore follows the row-availability test of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that latches the layer settings and restarts the layer |
| cfg_k | input | 2 | Kernel size, 1 or 3 |
| cfg_s | input | 2 | Stride, 1 or 2 |
| cfg_np | input | NP_W | Number of lanes in use, 1 to MAX_NP |
| cfg_width | input | COL_W | Input row width in pixels |
| wr_valid | input | 1 | An input word is offered |
| wr_data | input | WORD_W | Input word, PZ channel values of DATA_W bits each |
| wr_ready | output | 1 | A free row slot exists, so the offered word will be taken |
| out_valid | output | 1 | A window element is present on the active lanes |
| out_last | output | 1 | Final element of the current windows |
| out_lane_en | output | MAX_NP | Per-lane flag that the lane carries a real window |
| out_data | output | MAX_NP*WORD_W | Lane words, lane p at bits p*WORD_W upward |

## Verification
A wrong slot pointer shows up at the ports as a word from a neighbouring input row. The bench catches it on the first element that reads that slot, at most K+S-1 rows after the fault. A wrong release or completion count shows up as `wr_ready` or `out_valid` differing from the reference in the same cycle, because both outputs are compared on every clock against occupancy tracked in the bench. A column or lane mix-up corrupts the data or the lane mask of the very first affected element. Each test word encodes its own row and column, so the position error is visible directly in the failure line.

// File: rtl/mwlb_pkg.sv
package mwlb_pkg;
   localparam int KMAX      = 3;
   localparam int SMAX      = 2;
   localparam int NSLOT_MAX = KMAX + SMAX - 1;
   localparam int SLOT_W    = $clog2(NSLOT_MAX);

   typedef logic [1:0]      dim_t;
   typedef logic [SLOT_W:0] nslot_t;

   // ring slot arithmetic modulo the live slot count
   function automatic logic [SLOT_W-1:0] slot_add(input logic [SLOT_W-1:0] base,
                                                  input dim_t inc,
                                                  input nslot_t n);
      logic [SLOT_W+1:0] sum;
      sum = {2'b00, base} + {{SLOT_W{1'b0}}, inc};
      if (sum >= {1'b0, n})
         sum = sum - {1'b0, n};
      return sum[SLOT_W-1:0];
   endfunction
endpackage

// File: rtl/mwlb_cfg.sv
module mwlb_cfg
   import mwlb_pkg::*;
#(
   parameter int MAX_W  = 16,
   parameter int MAX_NP = 4,
   parameter int COL_W  = 5,
   parameter int NP_W   = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  dim_t             cfg_k,
   input  dim_t             cfg_s,
   input  logic [NP_W-1:0]  cfg_np,
   input  logic [COL_W-1:0] cfg_width,
   output dim_t             k,
   output dim_t             s,
   output logic [NP_W-1:0]  np,
   output logic [COL_W-1:0] width,
   output nslot_t           nslot,
   output logic [COL_W-1:0] out_w
);
   logic [COL_W-1:0] span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k     <= 2'd3;
         s     <= 2'd1;
         np    <= NP_W'(MAX_NP);
         width <= COL_W'(MAX_W);
      end else if (cfg_load) begin
         k     <= cfg_k;
         s     <= cfg_s;
         np    <= cfg_np;
         width <= cfg_width;
      end
   end

   // ring depth and number of output columns follow from the shape
   assign nslot = {1'b0, k} + {1'b0, s} - nslot_t'(1);
   assign span  = width - COL_W'(k);
   assign out_w = ((s == 2'd2) ? (span >> 1) : span) + COL_W'(1);
endmodule

// File: rtl/mwlb_wr_ctrl.sv
module mwlb_wr_ctrl
   import mwlb_pkg::*;
#(
   parameter int COL_W = 5,
   parameter int RC_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic              wr_valid,
   input  logic [COL_W-1:0]  width,
   input  nslot_t            nslot,
   input  logic [RC_W-1:0]   base_row,
   output logic              wr_ready,
   output logic              we,
   output logic [SLOT_W-1:0] we_slot,
   output logic [COL_W-1:0]  we_col,
   output logic [RC_W-1:0]   rows_done
);
   logic signed [RC_W-1:0] occ;

   // rows held beyond the reader's base; negative when stride skips rows
   assign occ      = rows_done - base_row;
   assign wr_ready = occ < $signed(RC_W'(nslot));
   assign we       = wr_valid & wr_ready & ~cfg_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_col    <= '0;
         we_slot   <= '0;
         rows_done <= '0;
      end else if (cfg_load) begin
         we_col    <= '0;
         we_slot   <= '0;
         rows_done <= '0;
      end else if (we) begin
         if (we_col == width - COL_W'(1)) begin
            we_col    <= '0;
            rows_done <= rows_done + RC_W'(1);
            we_slot   <= slot_add(we_slot, 2'd1, nslot);
         end else begin
            we_col <= we_col + COL_W'(1);
         end
      end
   end
endmodule

// File: rtl/mwlb_store.sv
module mwlb_store
   import mwlb_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int MAX_W  = 16,
   parameter int MAX_NP = 4,
   parameter int COL_W  = 5,
   parameter int CA_W   = 4
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [SLOT_W-1:0]              we_slot,
   input  logic [COL_W-1:0]               we_col,
   input  logic [WORD_W-1:0]              we_data,
   input  logic [SLOT_W-1:0]              rd_slot,
   input  logic [MAX_NP-1:0][CA_W-1:0]    rd_col,
   input  logic [MAX_NP-1:0]              rd_en,
   output logic [MAX_NP-1:0][WORD_W-1:0]  rd_data
);
   logic [WORD_W-1:0] mem [NSLOT_MAX][MAX_W];

   // single write port
   always_ff @(posedge clk) begin
      if (we)
         mem[we_slot][CA_W'(we_col)] <= we_data;
   end

   // one registered read port per lane, all on the same slot
   for (genvar p = 0; p < MAX_NP; p++) begin : g_rd
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else
            q <= rd_en[p] ? mem[rd_slot][rd_col[p]] : '0;
      end
      assign rd_data[p] = q;
   end
endmodule

// File: rtl/mwlb_seq.sv
module mwlb_seq
   import mwlb_pkg::*;
#(
   parameter int MAX_NP = 4,
   parameter int COL_W  = 5,
   parameter int CA_W   = 4,
   parameter int NP_W   = 3,
   parameter int RC_W   = 8
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_load,
   input  dim_t                        k,
   input  dim_t                        s,
   input  logic [NP_W-1:0]             np,
   input  logic [COL_W-1:0]            out_w,
   input  nslot_t                      nslot,
   input  logic [RC_W-1:0]             rows_done,
   output logic [RC_W-1:0]             base_row,
   output logic [SLOT_W-1:0]           rd_slot,
   output logic [MAX_NP-1:0][CA_W-1:0] rd_col,
   output logic [MAX_NP-1:0]           rd_en,
   output logic                        out_valid,
   output logic                        out_last,
   output logic [MAX_NP-1:0]           out_lane_en
);
   logic [SLOT_W-1:0]      base_slot;
   dim_t                   ky, kx, k_m1;
   logic [COL_W-1:0]       x0;
   logic [COL_W:0]         next_x0;
   logic signed [RC_W-1:0] have;
   logic                   issue, kx_end, ky_end, row_end;

   assign k_m1    = k - 2'd1;
   assign have    = rows_done - base_row;
   assign issue   = ~cfg_load & (have >= $signed(RC_W'(k)));
   assign kx_end  = (kx == k_m1);
   assign ky_end  = (ky == k_m1);
   assign next_x0 = {1'b0, x0} + (COL_W+1)'(np);
   assign row_end = next_x0 >= {1'b0, out_w};
   assign rd_slot = slot_add(base_slot, ky, nslot);

   for (genvar p = 0; p < MAX_NP; p++) begin : g_lane
      logic [COL_W:0] oc;
      logic           ok;
      assign oc = {1'b0, x0} + (COL_W+1)'(p);
      assign ok = (oc < {1'b0, out_w}) && (NP_W'(p) < np);
      assign rd_col[p] = (s == 2'd2) ? CA_W'({oc, 1'b0} + (COL_W+2)'(kx))
                                     : CA_W'(oc + (COL_W+1)'(kx));
      assign rd_en[p]  = issue & ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_row    <= '0;
         base_slot   <= '0;
         ky          <= '0;
         kx          <= '0;
         x0          <= '0;
         out_valid   <= 1'b0;
         out_last    <= 1'b0;
         out_lane_en <= '0;
      end else if (cfg_load) begin
         base_row    <= '0;
         base_slot   <= '0;
         ky          <= '0;
         kx          <= '0;
         x0          <= '0;
         out_valid   <= 1'b0;
         out_last    <= 1'b0;
         out_lane_en <= '0;
      end else begin
         out_valid   <= issue;
         out_last    <= issue & kx_end & ky_end;
         out_lane_en <= rd_en;
         if (issue) begin
            if (!kx_end) begin
               kx <= kx + 2'd1;
            end else begin
               kx <= '0;
               if (!ky_end) begin
                  ky <= ky + 2'd1;
               end else begin
                  ky <= '0;
                  if (row_end) begin
                     x0        <= '0;
                     base_row  <= base_row + RC_W'(s);
                     base_slot <= slot_add(base_slot, s, nslot);
                  end else begin
                     x0 <= next_x0[COL_W-1:0];
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/mwin_line_buffer.sv
module mwin_line_buffer
   import mwlb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PZ        = 4,
   parameter int MAX_W     = 16,
   parameter int MAX_NP    = 4,
   parameter int ROW_CNT_W = 8,
   localparam int WORD_W   = DATA_W * PZ,
   localparam int COL_W    = $clog2(MAX_W + 1),
   localparam int NP_W     = $clog2(MAX_NP + 1),
   localparam int CA_W     = $clog2(MAX_W)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_load,
   input  logic [1:0]               cfg_k,
   input  logic [1:0]               cfg_s,
   input  logic [NP_W-1:0]          cfg_np,
   input  logic [COL_W-1:0]         cfg_width,
   input  logic                     wr_valid,
   input  logic [WORD_W-1:0]        wr_data,
   output logic                     wr_ready,
   output logic                     out_valid,
   output logic                     out_last,
   output logic [MAX_NP-1:0]        out_lane_en,
   output logic [MAX_NP*WORD_W-1:0] out_data
);
   // elaboration-time parameter checks
   if (MAX_W < KMAX || (1 << CA_W) != MAX_W) begin : g_bad_width
      $error("MAX_W must be a power of two of at least the largest kernel");
   end
   if (MAX_NP < 1 || MAX_NP > 8) begin : g_bad_lanes
      $error("MAX_NP must lie in 1..8");
   end
   if (ROW_CNT_W < SLOT_W + 3) begin : g_bad_rowcnt
      $error("ROW_CNT_W too narrow for ring occupancy");
   end
   if (DATA_W < 1 || PZ < 1) begin : g_bad_word
      $error("DATA_W and PZ must be positive");
   end

   dim_t                        cur_k, cur_s;
   logic [NP_W-1:0]             cur_np;
   logic [COL_W-1:0]            cur_width, cur_out_w;
   nslot_t                      cur_nslot;
   logic                        we;
   logic [SLOT_W-1:0]           we_slot, rd_slot;
   logic [COL_W-1:0]            we_col;
   logic [ROW_CNT_W-1:0]        rows_done, base_row;
   logic [MAX_NP-1:0][CA_W-1:0] rd_col;
   logic [MAX_NP-1:0]           rd_en;
   logic [MAX_NP-1:0][WORD_W-1:0] rd_data;

   mwlb_cfg #(
      .MAX_W (MAX_W), .MAX_NP(MAX_NP), .COL_W(COL_W), .NP_W(NP_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_k    (cfg_k),
      .cfg_s    (cfg_s),
      .cfg_np   (cfg_np),
      .cfg_width(cfg_width),
      .k        (cur_k),
      .s        (cur_s),
      .np       (cur_np),
      .width    (cur_width),
      .nslot    (cur_nslot),
      .out_w    (cur_out_w)
   );

   mwlb_wr_ctrl #(
      .COL_W(COL_W), .RC_W(ROW_CNT_W)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .wr_valid (wr_valid),
      .width    (cur_width),
      .nslot    (cur_nslot),
      .base_row (base_row),
      .wr_ready (wr_ready),
      .we       (we),
      .we_slot  (we_slot),
      .we_col   (we_col),
      .rows_done(rows_done)
   );

   mwlb_store #(
      .WORD_W(WORD_W), .MAX_W(MAX_W), .MAX_NP(MAX_NP), .COL_W(COL_W), .CA_W(CA_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .we_slot(we_slot),
      .we_col (we_col),
      .we_data(wr_data),
      .rd_slot(rd_slot),
      .rd_col (rd_col),
      .rd_en  (rd_en),
      .rd_data(rd_data)
   );

   mwlb_seq #(
      .MAX_NP(MAX_NP), .COL_W(COL_W), .CA_W(CA_W), .NP_W(NP_W), .RC_W(ROW_CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_load   (cfg_load),
      .k          (cur_k),
      .s          (cur_s),
      .np         (cur_np),
      .out_w      (cur_out_w),
      .nslot      (cur_nslot),
      .rows_done  (rows_done),
      .base_row   (base_row),
      .rd_slot    (rd_slot),
      .rd_col     (rd_col),
      .rd_en      (rd_en),
      .out_valid  (out_valid),
      .out_last   (out_last),
      .out_lane_en(out_lane_en)
   );

   assign out_data = rd_data;
endmodule

// File: rtl/mwlb_chk.sv
module mwlb_chk
   import mwlb_pkg::*;
#(
   parameter int MAX_NP = 4,
   parameter int RC_W   = 8,
   parameter int COL_W  = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_load,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              out_valid,
   input logic              out_last,
   input logic [MAX_NP-1:0] out_lane_en,
   input logic [RC_W-1:0]   rows_done,
   input logic [RC_W-1:0]   base_row,
   input dim_t              k,
   input nslot_t            nslot,
   input logic [COL_W-1:0]  wr_col
);
   // R5: idle cycles carry no lanes
   assert_idle_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_lane_en == '0);

   // R5: active lanes form a run starting at lane 0
   assert_lane_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_lane_en[0] && (((out_lane_en + MAX_NP'(1)) & out_lane_en) == '0));

   // R7: writer never runs more than the ring depth ahead of the reader
   assert_ring_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(rows_done - base_row) <= $signed(RC_W'(nslot)));

   // R7: a refused word moves neither the column nor the row count
   assert_refused_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !cfg_load) |=> $stable(wr_col) && $stable(rows_done));

   // R9: a load silences the output for the following cycle
   assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> !out_valid);

   // R6: an element was only issued with all covered rows complete
   assert_rows_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $signed($past(rows_done) - $past(base_row)) >= $signed(RC_W'($past(k))));

   // R3: the window-end marker only rides on a valid element
   assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

bind mwin_line_buffer mwlb_chk #(
   .MAX_NP(MAX_NP), .RC_W(ROW_CNT_W), .COL_W(COL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_load   (cfg_load),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .out_valid  (out_valid),
   .out_last   (out_last),
   .out_lane_en(out_lane_en),
   .rows_done  (rows_done),
   .base_row   (base_row),
   .k          (cur_k),
   .nslot      (cur_nslot),
   .wr_col     (we_col)
);

// File: tb/tb_mwin_line_buffer.sv
module tb_mwin_line_buffer;
   localparam int NP = 4;
   localparam int WW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_load = 1'b0;
   logic [1:0]      cfg_k = 2'd3;
   logic [1:0]      cfg_s = 2'd1;
   logic [2:0]      cfg_np = 3'd4;
   logic [4:0]      cfg_width = 5'd16;
   logic            wr_valid = 1'b0;
   logic [WW-1:0]   wr_data = '0;
   logic            wr_ready;
   logic            out_valid;
   logic            out_last;
   logic [NP-1:0]   out_lane_en;
   logic [NP*WW-1:0] out_data;

   always #4 clk = ~clk;

   mwin_line_buffer dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_k(cfg_k), .cfg_s(cfg_s),
      .cfg_np(cfg_np), .cfg_width(cfg_width), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .out_valid(out_valid), .out_last(out_last),
      .out_lane_en(out_lane_en), .out_data(out_data)
   );

   typedef struct {
      logic [NP-1:0]    en;
      logic [NP*WW-1:0] data;
      bit               last;
      bit               rowend;
   } exp_t;

   exp_t q[$];
   int   vecs = 0;
   int   miss = 0;
   int   gcyc = 0;

   always @(posedge clk) gcyc <= gcyc + 1;

   function automatic logic [WW-1:0] pix(input int r, input int c);
      return {8'(r), 8'(c), 8'(r * 13 + c * 7 + 1), 8'hC3 ^ 8'(c)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [NP*WW-1:0] act, input logic [NP*WW-1:0] exp);
      vecs++;
      if (!ok) begin
         miss++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic build(input int k, input int s, input int np, input int w, input int h);
      int ow, oh;
      exp_t e;
      ow = (w - k) / s + 1;
      oh = (h - k) / s + 1;
      q.delete();
      for (int r = 0; r < oh; r++)
         for (int x0 = 0; x0 < ow; x0 += np)
            for (int ky = 0; ky < k; ky++)
               for (int kx = 0; kx < k; kx++) begin
                  e.en   = '0;
                  e.data = '0;
                  for (int p = 0; p < np; p++)
                     if (x0 + p < ow) begin
                        e.en[p] = 1'b1;
                        e.data[p*WW +: WW] = pix(r * s + ky, (x0 + p) * s + kx);
                     end
                  e.last   = (ky == k - 1) && (kx == k - 1);
                  e.rowend = e.last && (x0 + np >= ow);
                  q.push_back(e);
               end
   endtask

   // limit: number of words to write; a value below w*h cuts the layer short
   task automatic run_layer(input int k, input int s, input int np, input int w,
                            input int h, input bit gaps, input int limit);
      int rows_w, rel, sent, nslot, cyc;
      bit prev_avail, prev_we;
      exp_t e;
      build(k, s, np, w, h);
      nslot = k + s - 1;
      @(negedge clk);
      cfg_load  = 1'b1;
      cfg_k     = 2'(k);
      cfg_s     = 2'(s);
      cfg_np    = 3'(np);
      cfg_width = 5'(w);
      wr_valid  = 1'b1;
      wr_data   = 32'hFEED_0000;
      @(negedge clk);
      cfg_load = 1'b0;
      // R9: quiet and empty right after the load
      check(out_valid === 1'b0, "R9", "out_valid after load", NP*WW'(out_valid), '0);
      check(out_lane_en === '0, "R9", "lane_en after load", NP*WW'(out_lane_en), '0);
      check(wr_ready === 1'b1, "R9", "wr_ready after load", NP*WW'(wr_ready), 1);
      rows_w = 0; rel = 0; sent = 0; prev_avail = 1'b0; prev_we = 1'b0; cyc = 0;
      while ((sent < limit || (limit == w * h && q.size() > 0)) && cyc < 4000) begin
         // drive the next offer; a refused offer carries junk (R7)
         if (sent < limit && (!gaps || ((gcyc * 7 + 3) % 5) != 0)) begin
            wr_valid = 1'b1;
            wr_data  = wr_ready ? pix(sent / w, sent % w) : (32'hBAD0_0000 | 32'(sent));
            prev_we  = wr_ready;
         end else begin
            wr_valid = 1'b0;
            wr_data  = '0;
            prev_we  = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (prev_we) begin
            sent++;
            if (sent % w == 0) rows_w++;
         end
         // R6,R10: valid follows the row test of the previous cycle
         check(out_valid === prev_avail, "R6,R10", "out_valid",
               NP*WW'(out_valid), NP*WW'(prev_avail));
         if (out_valid === 1'b1) begin
            if (q.size() == 0) begin
               check(1'b0, "R6", "element beyond expected stream", NP*WW'(out_lane_en), '0);
            end else begin
               e = q.pop_front();
               check(out_lane_en === e.en, "R5", "lane_en", NP*WW'(out_lane_en), NP*WW'(e.en));
               check(out_data === e.data, "R2,R4", "lane data", out_data, e.data);
               check(out_last === e.last, "R3", "out_last", NP*WW'(out_last), NP*WW'(e.last));
               if (e.rowend) rel += s;
            end
         end else begin
            check(out_lane_en === '0, "R5", "lane_en while idle", NP*WW'(out_lane_en), '0);
         end
         // R7,R8: ready tracks the free slot count after releases
         check(wr_ready === ((rows_w - rel) < nslot), "R7,R8", "wr_ready",
               NP*WW'(wr_ready), NP*WW'((rows_w - rel) < nslot));
         prev_avail = (rows_w - rel) >= k;
      end
      wr_valid = 1'b0;
      check(cyc < 4000, "R6", "layer did not complete", NP*WW'(q.size()), '0);
      q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(out_valid === 1'b0, "R1", "out_valid in reset", NP*WW'(out_valid), '0);
      check(wr_ready === 1'b1, "R1", "wr_ready in reset", NP*WW'(wr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "out_valid after reset", NP*WW'(out_valid), '0);
      check(out_lane_en === '0, "R1", "lane_en after reset", NP*WW'(out_lane_en), '0);
      check(wr_ready === 1'b1, "R1", "wr_ready after reset", NP*WW'(wr_ready), 1);

      run_layer(3, 1, 4, 16, 6, 1'b0, 96);   // full lanes, stride 1
      run_layer(3, 2, 3, 15, 7, 1'b1, 105);  // stride 2, partial final group
      run_layer(1, 1, 2, 9, 3, 1'b1, 27);    // single-slot ring
      run_layer(1, 2, 4, 8, 5, 1'b0, 40);    // skipped rows between outputs
      run_layer(3, 1, 4, 16, 6, 1'b0, 40);   // cut short, then reloaded (R9)
      run_layer(3, 1, 1, 3, 4, 1'b1, 12);    // one lane, minimum width

      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miss++;
      $display("FAIL watchdog all-R actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule